// File: doc/BRIEF.md
# Subcode Text Pack Buffer with Serial Readout

This block gathers the six-bit R–W subcode symbols of one text pack, assembles them into bytes and keeps the sixteen payload bytes in a two-half byte buffer. As the bytes arrive, a running CRC-16 is computed over the payload. The two trailing check bytes are then compared against the inverted CRC. When the last symbol of a pack has been taken, the block tells the host by pulling its ready line low for a fixed number of clock cycles. At the same moment it places a pass/fail flag on the serial data line.

The host then clocks the 128 payload bits out on a serial clock. It may run that clock at any rate slower than the internal clock. While the host reads one half of the buffer, the next pack is written into the other half. A pack-start pulse arms the collector. A sync-error input marks the current pack as untrustworthy, which forces its flag to the fail value.

Top module: `tpk_pack_buffer`

## Requirements
- R1: After reset, `ready_n` is high and `sdata` is low.
- R2: Symbols s0..s23 form bytes big-endian: for each group k, byte 3k = {s4k, s4k+1[5:4]}, byte 3k+1 = {s4k+1[3:0], s4k+2[5:2]}, byte 3k+2 = {s4k+2[1:0], s4k+3}. Bytes 0–15 are the payload and bytes 16–17 are the check field.
- R3: `ready_n` falls after the second rising clock edge that follows the edge accepting symbol 23, and it is still high after the first.
- R4: When `ready_n` falls, `sdata` shows the flag. The flag is 1 only if {byte16, byte17} equals the bitwise inverse of the CRC-16 over bytes 0–15, where the CRC uses polynomial 0x1021, initial value 0x0000, MSB first.
- R5: If `sync_err` is high in any cycle from the `pack_sync` pulse up to and including the cycle of symbol 23, the flag is 0.
- R6: `ready_n` stays low for exactly READY_LEN clock cycles and then returns high.
- R7: Each falling edge of `sclk` advances `sdata` to the next payload bit. The order starts with byte 0 MSB and ends with byte 15 LSB, 128 bits in all, and the host samples each bit before raising `sclk`.
- R8: The falling edge that follows the 128th bit drives `sdata` low. Further `sclk` edges leave it low until the next pack completes.
- R9: Symbols that arrive after reset or after a completed pack without a new `pack_sync` are ignored and do not lower `ready_n`.
- R10: A `pack_sync` in the middle of a pack discards the partial pack and restarts collection at symbol 0.
- R11: A pack being received does not alter the data of the pack currently being read out.
- R12: A pack that completes during a readout restarts the readout. The new pack's flag is shown first, followed by its 128 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pack_sync | input | 1 | One-cycle pulse that starts a new pack |
| sync_err | input | 1 | Sync interpolation or rejection event for the current pack |
| sym_valid | input | 1 | `sym_data` carries a symbol this cycle |
| sym_data | input | 6 | R–W symbol, R in the MSB |
| sclk | input | 1 | Host serial clock, idles high |
| ready_n | output | 1 | Pack-ready strobe, active low |
| sdata | output | 1 | Flag, then serial payload bits |

## Verification
The in-line properties check the following on every cycle:
- byte indices stay inside the pack;
- a completed pack is always preceded by its final check byte;
- a flagged sync error always forces a fail;
- no byte is produced while the collector is disarmed;
- the bit counter holds still when no readout is running;
- every fall of the ready line starts a fresh readout.

Other behaviours need whole scenarios, so only the bench shows them: the bit ordering of the packing, a correct CRC verdict on good and corrupted packs, the exact strobe latency and width, isolation of the two buffer halves, and the abort and restart orderings.

// File: rtl/tpk_pkg.sv
// Package: pack geometry and the CRC-16 byte step shared by the pack buffer.
// Assumes the pack layout is fixed: 24 six-bit symbols, 16 payload bytes, 2 check bytes.
package tpk_pkg;
    localparam int SYM_W      = 6;
    localparam int BYTE_W     = 8;
    localparam int PACK_SYMS  = 24;
    localparam int PACK_BYTES = 18;
    localparam int DATA_BYTES = 16;
    localparam int IDX_W      = $clog2(PACK_SYMS);
    localparam int CRC_W      = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    localparam int BUF_WORDS  = 2 * DATA_BYTES;
    localparam int READ_BITS  = DATA_BYTES * BYTE_W;

    // Advance the CRC by one byte, MSB first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                   input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            if (r[CRC_W-1] ^ d[i]) r = (r << 1) ^ CRC_POLY;
            else                   r = r << 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/tpk_symbol_packer.sv
// Symbol packer: turns 24 six-bit symbols into 18 bytes, four symbols per three bytes.
// Assumes pack_sync arms it; it disarms itself after symbol 23 and tracks sync errors.
module tpk_symbol_packer
    import tpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pack_sync_i,
    input  logic              sync_err_i,
    input  logic              sym_valid_i,
    input  logic [SYM_W-1:0]  sym_i,
    output logic              byte_valid_o,
    output logic [IDX_W-1:0]  byte_idx_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              pack_err_o
);
    localparam logic [IDX_W-1:0] LAST_SYM = IDX_W'(PACK_SYMS - 1);

    logic             armed;
    logic [IDX_W-1:0] sym_cnt;
    logic [SYM_W-1:0] hold;
    logic [1:0]       phase;
    logic [IDX_W-1:0] grp_base;

    assign phase    = sym_cnt[1:0];
    assign grp_base = IDX_W'(sym_cnt[IDX_W-1:2]) * IDX_W'(3);

    // Count symbols, splice residual bits into bytes, and keep the pack error sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed        <= 1'b0;
            sym_cnt      <= '0;
            hold         <= '0;
            byte_valid_o <= 1'b0;
            byte_idx_o   <= '0;
            byte_o       <= '0;
            pack_err_o   <= 1'b0;
        end else begin
            byte_valid_o <= 1'b0;
            if (pack_sync_i) begin
                armed      <= 1'b1;
                sym_cnt    <= '0;
                pack_err_o <= sync_err_i;
            end else if (armed) begin
                if (sync_err_i) pack_err_o <= 1'b1;
                if (sym_valid_i) begin
                    sym_cnt <= sym_cnt + IDX_W'(1);
                    if (sym_cnt == LAST_SYM) armed <= 1'b0;
                    case (phase)
                        2'd0: hold <= sym_i;
                        2'd1: begin
                            byte_o       <= {hold, sym_i[5:4]};
                            hold         <= {2'b00, sym_i[3:0]};
                            byte_idx_o   <= grp_base;
                            byte_valid_o <= 1'b1;
                        end
                        2'd2: begin
                            byte_o       <= {hold[3:0], sym_i[5:2]};
                            hold         <= {4'b0000, sym_i[1:0]};
                            byte_idx_o   <= grp_base + IDX_W'(1);
                            byte_valid_o <= 1'b1;
                        end
                        default: begin
                            byte_o       <= {hold[1:0], sym_i};
                            byte_idx_o   <= grp_base + IDX_W'(2);
                            byte_valid_o <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    assert_byte_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> (byte_idx_o < IDX_W'(PACK_BYTES)));

    assert_disarmed_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !pack_sync_i) |=> !byte_valid_o);
endmodule

// File: rtl/tpk_crc_check.sv
// CRC checker: runs the CRC-16 over payload bytes as they stream past, latches the
// first check byte, and on the last byte raises done with the pass verdict.
// Assumes bytes arrive in index order, starting with index 0.
module tpk_crc_check
    import tpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid_i,
    input  logic [IDX_W-1:0]  byte_idx_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              pack_err_i,
    output logic              done_o,
    output logic              pass_o
);
    localparam logic [IDX_W-1:0] IDX_CHK_HI = IDX_W'(DATA_BYTES);
    localparam logic [IDX_W-1:0] IDX_CHK_LO = IDX_W'(DATA_BYTES + 1);

    logic [CRC_W-1:0]  crc;
    logic [BYTE_W-1:0] chk_hi;
    logic [CRC_W-1:0]  crc_seed;

    assign crc_seed = (byte_idx_i == '0) ? '0 : crc;

    // Accumulate the CRC, hold the high check byte, and deliver the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc    <= '0;
            chk_hi <= '0;
            done_o <= 1'b0;
            pass_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (byte_valid_i) begin
                if (byte_idx_i < IDX_CHK_HI) crc <= crc_step(crc_seed, byte_i);
                if (byte_idx_i == IDX_CHK_HI) chk_hi <= byte_i;
                if (byte_idx_i == IDX_CHK_LO) begin
                    done_o <= 1'b1;
                    pass_o <= ({chk_hi, byte_i} == ~crc) && !pack_err_i;
                end
            end
        end
    end

    assert_done_after_check_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(byte_valid_i && (byte_idx_i == IDX_CHK_LO)));

    assert_sync_err_fails_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(pack_err_i)) |-> !pass_o);
endmodule

// File: rtl/tpk_readout_port.sv
// Readout port: two-half byte buffer, ready strobe, and a serial shifter paced by the
// host clock. Assumes sclk is slower than clk; it is resynchronised and edge-detected.
module tpk_readout_port
    import tpk_pkg::*;
#(
    parameter int READY_LEN   = 2304,
    parameter int SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic [$clog2(DATA_BYTES)-1:0]  wr_addr_i,
    input  logic [BYTE_W-1:0]              wr_data_i,
    input  logic                           done_i,
    input  logic                           pass_i,
    input  logic                           sclk_i,
    output logic                           ready_n_o,
    output logic                           sdata_o
);
    localparam int HALF_AW = $clog2(DATA_BYTES);
    localparam int CNT_W   = $clog2(READ_BITS + 1);
    localparam int LOW_W   = $clog2(READY_LEN + 1);

    logic [BYTE_W-1:0]    mem [BUF_WORDS];
    logic                 wr_half;
    logic                 rd_half;
    logic [SYNC_STAGES:0] sclk_q;
    logic                 sclk_fall;
    logic [CNT_W-1:0]     bit_cnt;
    logic                 active;
    logic [LOW_W-1:0]     low_cnt;
    logic [BYTE_W-1:0]    rd_byte;

    assign sclk_fall = sclk_q[SYNC_STAGES] & ~sclk_q[SYNC_STAGES-1];
    assign rd_byte   = mem[{rd_half, bit_cnt[HALF_AW+2:3]}];

    // Write payload bytes into the half not being read.
    always_ff @(posedge clk) begin
        if (wr_en_i) mem[{wr_half, wr_addr_i}] <= wr_data_i;
    end

    // Swap buffer halves when a pack completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_half <= 1'b0;
            rd_half <= 1'b1;
        end else if (done_i) begin
            rd_half <= wr_half;
            wr_half <= ~wr_half;
        end
    end

    // Resynchronise the host clock into the internal domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= '1;
        else        sclk_q <= {sclk_q[SYNC_STAGES-1:0], sclk_i};
    end

    // Time the low strobe for READY_LEN cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_n_o <= 1'b1;
            low_cnt   <= '0;
        end else if (done_i) begin
            ready_n_o <= 1'b0;
            low_cnt   <= LOW_W'(READY_LEN - 1);
        end else if (!ready_n_o) begin
            if (low_cnt == '0) ready_n_o <= 1'b1;
            else               low_cnt   <= low_cnt - LOW_W'(1);
        end
    end

    // Present the flag, then shift one payload bit per host falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdata_o <= 1'b0;
            bit_cnt <= '0;
            active  <= 1'b0;
        end else if (done_i) begin
            sdata_o <= pass_i;
            bit_cnt <= '0;
            active  <= 1'b1;
        end else if (sclk_fall && active) begin
            if (bit_cnt == CNT_W'(READ_BITS)) begin
                sdata_o <= 1'b0;
                active  <= 1'b0;
            end else begin
                sdata_o <= rd_byte[3'd7 - bit_cnt[2:0]];
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
        end
    end

    assert_restart_on_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_n_o) |-> (active && (bit_cnt == '0)));

    assert_idle_counter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(active) && !$past(done_i)) |-> $stable(bit_cnt));

    assert_bit_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(READ_BITS));
endmodule

// File: rtl/tpk_pack_buffer.sv
// Top: collects a text pack, checks it, and serves it to the host over a strobe and
// a serial line. Assumes one clock domain; the host serial clock is sampled in it.
module tpk_pack_buffer
    import tpk_pkg::*;
#(
    parameter int READY_LEN   = 2304,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pack_sync,
    input  logic             sync_err,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_data,
    input  logic             sclk,
    output logic             ready_n,
    output logic             sdata
);
    localparam int HALF_AW = $clog2(DATA_BYTES);

    logic              byte_valid;
    logic [IDX_W-1:0]  byte_idx;
    logic [BYTE_W-1:0] byte_data;
    logic              pack_err;
    logic              done;
    logic              pass;
    logic              wr_en;

    assign wr_en = byte_valid && (byte_idx < IDX_W'(DATA_BYTES));

    tpk_symbol_packer u_packer (
        .clk          (clk),
        .rst_n        (rst_n),
        .pack_sync_i  (pack_sync),
        .sync_err_i   (sync_err),
        .sym_valid_i  (sym_valid),
        .sym_i        (sym_data),
        .byte_valid_o (byte_valid),
        .byte_idx_o   (byte_idx),
        .byte_o       (byte_data),
        .pack_err_o   (pack_err)
    );

    tpk_crc_check u_crc (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_valid_i (byte_valid),
        .byte_idx_i   (byte_idx),
        .byte_i       (byte_data),
        .pack_err_i   (pack_err),
        .done_o       (done),
        .pass_o       (pass)
    );

    tpk_readout_port #(
        .READY_LEN   (READY_LEN),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_readout (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (byte_idx[HALF_AW-1:0]),
        .wr_data_i (byte_data),
        .done_i    (done),
        .pass_i    (pass),
        .sclk_i    (sclk),
        .ready_n_o (ready_n),
        .sdata_o   (sdata)
    );
endmodule

// File: tb/tpk_pack_buffer_bench.sv
`timescale 1ns/1ps
module tpk_pack_buffer_bench;
    localparam int READY_LEN = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pack_sync = 1'b0;
    logic       sync_err = 1'b0;
    logic       sym_valid = 1'b0;
    logic [5:0] sym_data = '0;
    logic       sclk = 1'b1;
    logic       ready_n;
    logic       sdata;

    int errors = 0;
    int checks = 0;

    logic [7:0]   pk [18];
    logic [5:0]   sy [24];
    logic [127:0] expd;

    // {seed, corrupt check field, inject sync error, expected flag}
    localparam logic [10:0] VEC [6] = '{
        {8'h11, 1'b0, 1'b0, 1'b1},
        {8'h5A, 1'b1, 1'b0, 1'b0},
        {8'hC3, 1'b0, 1'b1, 1'b0},
        {8'h00, 1'b0, 1'b0, 1'b1},
        {8'hFF, 1'b0, 1'b0, 1'b1},
        {8'h27, 1'b1, 1'b1, 1'b0}
    };

    always #2.5 clk = ~clk;

    tpk_pack_buffer #(.READY_LEN(READY_LEN)) u_tpk_pack_buffer (
        .clk(clk), .rst_n(rst_n), .pack_sync(pack_sync), .sync_err(sync_err),
        .sym_valid(sym_valid), .sym_data(sym_data), .sclk(sclk),
        .ready_n(ready_n), .sdata(sdata)
    );

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Build a pack from a seed: payload, CRC check field, symbols, expected bits.
    task automatic build_pack(input logic [7:0] seed, input bit corrupt);
        logic [15:0] c;
        logic [15:0] chk;
        c = 16'h0000;
        for (int i = 0; i < 16; i++) begin
            pk[i] = seed ^ (8'(i) * 8'd29 + 8'd7);
            for (int b = 7; b >= 0; b--) begin
                if (c[15] ^ pk[i][b]) c = (c << 1) ^ 16'h1021;
                else                  c = c << 1;
            end
        end
        chk = ~c;
        if (corrupt) chk = chk ^ 16'h0100;
        pk[16] = chk[15:8];
        pk[17] = chk[7:0];
        for (int k = 0; k < 6; k++) begin
            sy[4*k]   = pk[3*k][7:2];
            sy[4*k+1] = {pk[3*k][1:0], pk[3*k+1][7:4]};
            sy[4*k+2] = {pk[3*k+1][3:0], pk[3*k+2][7:6]};
            sy[4*k+3] = pk[3*k+2][5:0];
        end
        for (int i = 0; i < 16; i++) expd[127-8*i -: 8] = pk[i];
    endtask

    task automatic do_sync;
        pack_sync = 1'b1;
        tick;
        pack_sync = 1'b0;
    endtask

    task automatic send_syms(input int from, input int upto, input int err_at);
        for (int i = from; i <= upto; i++) begin
            sym_valid = 1'b1;
            sym_data  = sy[i];
            sync_err  = (i == err_at);
            tick;
        end
        sym_valid = 1'b0;
        sync_err  = 1'b0;
    endtask

    // Called right after the edge that took symbol 23.
    task automatic expect_ready(input logic flag, input string ftag);
        int n;
        check(ready_n === 1'b1, "R3", "ready high one edge after last symbol", 128'(ready_n), 128'd1);
        tick;
        check(ready_n === 1'b1, "R3", "ready high two edges after last symbol", 128'(ready_n), 128'd1);
        tick;
        check(ready_n === 1'b0, "R3", "ready fell", 128'(ready_n), 128'd0);
        check(sdata === flag, ftag, "flag on sdata", 128'(sdata), 128'(flag));
        n = 1;
        while (ready_n === 1'b0 && n < READY_LEN + 20) begin
            tick;
            if (ready_n === 1'b0) n++;
        end
        check(n == READY_LEN, "R6", "ready low width", 128'(n), 128'(READY_LEN));
    endtask

    task automatic read_bits(input int n, output logic [127:0] v);
        v = '0;
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0;
            repeat (6) tick;
            v[127-i] = sdata;
            sclk = 1'b1;
            repeat (6) tick;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [127:0] got;
        logic [127:0] exp_a;
        int lows;
        repeat (4) tick;
        rst_n = 1'b1;
        tick;
        check(ready_n === 1'b1, "R1", "ready after reset", 128'(ready_n), 128'd1);
        check(sdata === 1'b0, "R1", "sdata after reset", 128'(sdata), 128'd0);

        // R9: symbols without a pack start after reset
        build_pack(8'h77, 1'b0);
        send_syms(0, 23, -1);
        lows = 0;
        repeat (10) begin tick; if (ready_n !== 1'b1) lows++; end
        check(lows == 0, "R9", "no strobe without pack start", 128'(lows), 128'd0);
        check(sdata === 1'b0, "R9", "sdata untouched", 128'(sdata), 128'd0);

        // Table walk: R2, R4, R5, R6, R7, R8
        for (int v = 0; v < 6; v++) begin
            build_pack(VEC[v][10:3], VEC[v][2]);
            do_sync;
            send_syms(0, 23, VEC[v][1] ? 10 : -1);
            expect_ready(VEC[v][0], VEC[v][1] ? "R5" : "R4");
            read_bits(128, got);
            check(got === expd, "R7", "payload bits (R2 packing)", got, expd);
            sclk = 1'b0; repeat (6) tick;
            check(sdata === 1'b0, "R8", "sdata low after burst", 128'(sdata), 128'd0);
            sclk = 1'b1; repeat (6) tick;
            sclk = 1'b0; repeat (6) tick;
            check(sdata === 1'b0, "R8", "extra edge ignored", 128'(sdata), 128'd0);
            sclk = 1'b1; repeat (6) tick;
        end

        // R9: symbols after a completed pack without a new start
        send_syms(0, 23, -1);
        lows = 0;
        repeat (10) begin tick; if (ready_n !== 1'b1) lows++; end
        check(lows == 0, "R9", "no strobe after completion", 128'(lows), 128'd0);

        // R10: restart in mid-pack
        build_pack(8'h99, 1'b0);
        do_sync;
        send_syms(0, 9, -1);
        build_pack(8'h3C, 1'b0);
        do_sync;
        send_syms(0, 23, -1);
        expect_ready(1'b1, "R10");
        read_bits(128, got);
        check(got === expd, "R10", "restarted pack data", got, expd);

        // R11: receiving a pack leaves the pack in readout intact
        build_pack(8'h41, 1'b0);
        do_sync;
        send_syms(0, 23, -1);
        expect_ready(1'b1, "R4");
        exp_a = expd;
        build_pack(8'h82, 1'b0);
        do_sync;
        send_syms(0, 19, -1);
        read_bits(128, got);
        check(got === exp_a, "R11", "old pack while new is written", got, exp_a);
        send_syms(20, 23, -1);
        expect_ready(1'b1, "R11");
        read_bits(128, got);
        check(got === expd, "R11", "new pack after completion", got, expd);

        // R12: completion during a readout restarts it
        build_pack(8'h13, 1'b0);
        do_sync;
        send_syms(0, 23, -1);
        expect_ready(1'b1, "R4");
        read_bits(40, got);
        build_pack(8'h64, 1'b0);
        do_sync;
        send_syms(0, 23, -1);
        expect_ready(1'b1, "R12");
        read_bits(128, got);
        check(got === expd, "R12", "restarted readout data", got, expd);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule